// File: doc/BRIEF.md
# PWM Force Output Override Stage

This block sits between eight PWM waveform outputs and their pins and can override any channel with a fixed level or with high impedance. A command word holds a two-bit force code for each channel. Whether a channel is forced at a given moment depends on an enable that is picked per channel: either an external force input, with programmable polarity, or a software force bit.

The command word has two stages. Register writes go to a shadow copy. A load-timing selection decides when the shadow is copied into the active copy that drives the override: on the write itself, on a counter-reload pulse, on a sync input, or never. A second option replaces the timing selection and loads the shadow when one comparator, chosen by index, reports a match. A per-channel output enable gates each pin. Pin level and pin enable are registered, so each reflects the inputs of the cycle before.

Top module: `pwm_force_stage`

## Requirements
- R1: Channel i takes its force code from bits [2i+1:2i] of the active command. Code 0 drives the pin low and code 1 drives it high, with pin_oe high in both cases.
- R2: Code 2 puts the pin in high impedance: pin_oe low and pin_out held at 0.
- R3: Bit i of src_sel chooses what enables forcing on channel i: 0 selects the external force input and 1 selects sw_force.
- R4: force_pol set to 0 makes force_in active high. Set to 1, it makes force_in active low.
- R5: If forcing is not enabled on a channel, or its code is 3, the channel passes its pwm_in level with pin_oe high.
- R6: If ch_oe[i] is 0, the pin is released (pin_oe[i]=0, pin_out[i]=0) whatever the code and the force enable.
- R7: cmd_wr stores cmd_wdata in the shadow. With load_mode 0, the same write also loads the active command.
- R8: With load_mode 1, the active command loads from the shadow only on a cycle where reload_pulse is high.
- R9: With load_mode 2, the active command loads only on a cycle where sync_in is high. reload_pulse has no effect.
- R10: With load_mode 3, the active command never loads, and writes reach only the shadow.
- R11: While cmp_load_en is high, load_mode is ignored. The active command loads only when cmp_match[cmp_sel] is high, and matches from other comparators do nothing.
- R12: If a write and a load event fall in the same cycle, the active command takes the newly written value.
- R13: While rst is high, pin_out and pin_oe are all 0 and the active and shadow commands become all code 3 (no force).
- R14: pin_out and pin_oe change one clock edge after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | NUM_CH | Raw PWM levels |
| force_in | input | 1 | External force request |
| force_pol | input | 1 | External force polarity, 1 = active low |
| sw_force | input | 1 | Software force bit |
| src_sel | input | NUM_CH | Per-channel force source, 1 = software |
| ch_oe | input | NUM_CH | Per-channel output enable |
| load_mode | input | 2 | Shadow-to-active load timing |
| cmp_load_en | input | 1 | Load on selected comparator match instead |
| cmp_sel | input | CMP_IDX_W | Index of the comparator used for loading |
| cmp_match | input | NUM_CMP | Comparator match pulses |
| reload_pulse | input | 1 | Counter reload pulse |
| sync_in | input | 1 | Sync input pulse |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 2*NUM_CH | Command write data |
| pin_out | output | NUM_CH | Pin data level |
| pin_oe | output | NUM_CH | Pin output enable |

## Verification
The assertions assume load_mode, cmp_load_en and cmd_wdata are valid in every cycle after reset, and that cmp_sel stays below NUM_CMP. Load events are treated as single-cycle strobes whose effect shows up at the next edge. The stimulus drives every input on the falling clock edge, so each strobe lasts exactly one cycle. It keeps cmp_sel in range and selects the comparator load option only in the directed test for it.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

  typedef enum logic [1:0] {
    CODE_LOW  = 2'd0,
    CODE_HIGH = 2'd1,
    CODE_HIZ  = 2'd2,
    CODE_PASS = 2'd3
  } force_code_e;

  typedef enum logic [1:0] {
    LOAD_NOW    = 2'd0,
    LOAD_RELOAD = 2'd1,
    LOAD_SYNC   = 2'd2,
    LOAD_NEVER  = 2'd3
  } load_mode_e;

  localparam int CODE_W = 2;

endpackage

// File: rtl/pfo_cmd_buffer.sv
module pfo_cmd_buffer
  import pfo_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_CMP   = 8,
  parameter int CMP_IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_wr,
  input  logic [CODE_W*NUM_CH-1:0]   cmd_wdata,
  input  logic [1:0]                 load_mode,
  input  logic                       cmp_load_en,
  input  logic [CMP_IDX_W-1:0]       cmp_sel,
  input  logic [NUM_CMP-1:0]         cmp_match,
  input  logic                       reload_pulse,
  input  logic                       sync_in,
  output logic [CODE_W*NUM_CH-1:0]   active_cmd
);

  localparam int CMD_W = CODE_W * NUM_CH;

  logic [CMD_W-1:0] shadow_q;
  logic [CMD_W-1:0] shadow_next;
  logic             load_evt;

  // A write in the same cycle as a load event feeds the new word straight through
  assign shadow_next = cmd_wr ? cmd_wdata : shadow_q;

  always_comb begin
    load_evt = 1'b0;
    if (cmp_load_en) begin
      load_evt = cmp_match[cmp_sel];
    end else begin
      unique case (load_mode_e'(load_mode))
        LOAD_NOW:    load_evt = cmd_wr;
        LOAD_RELOAD: load_evt = reload_pulse;
        LOAD_SYNC:   load_evt = sync_in;
        LOAD_NEVER:  load_evt = 1'b0;
        default:     load_evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q   <= '1;
      active_cmd <= '1;
    end else begin
      shadow_q <= shadow_next;
      if (load_evt) begin
        active_cmd <= shadow_next;
      end
    end
  end

endmodule

// File: rtl/pfo_force_enable.sv
module pfo_force_enable #(
  parameter int NUM_CH = 8
) (
  input  logic              force_in,
  input  logic              force_pol,
  input  logic              sw_force,
  input  logic [NUM_CH-1:0] src_sel,
  output logic [NUM_CH-1:0] force_en
);

  logic ext_active;

  assign ext_active = force_in ^ force_pol;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_src
    assign force_en[g] = src_sel[g] ? sw_force : ext_active;
  end

endmodule

// File: rtl/pfo_channel_mux.sv
module pfo_channel_mux
  import pfo_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        pwm_in,
  input  logic [NUM_CH-1:0]        force_en,
  input  logic [NUM_CH-1:0]        ch_oe,
  input  logic [CODE_W*NUM_CH-1:0] active_cmd,
  output logic [NUM_CH-1:0]        pin_out,
  output logic [NUM_CH-1:0]        pin_oe
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    force_code_e code;
    logic        lvl_d;
    logic        oe_d;

    assign code = force_code_e'(active_cmd[CODE_W*g +: CODE_W]);

    always_comb begin
      lvl_d = pwm_in[g];
      oe_d  = 1'b1;
      if (!ch_oe[g]) begin
        lvl_d = 1'b0;
        oe_d  = 1'b0;
      end else if (force_en[g]) begin
        unique case (code)
          CODE_LOW:  begin lvl_d = 1'b0;      oe_d = 1'b1; end
          CODE_HIGH: begin lvl_d = 1'b1;      oe_d = 1'b1; end
          CODE_HIZ:  begin lvl_d = 1'b0;      oe_d = 1'b0; end
          CODE_PASS: begin lvl_d = pwm_in[g]; oe_d = 1'b1; end
          default:   begin lvl_d = pwm_in[g]; oe_d = 1'b1; end
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[g] <= 1'b0;
        pin_oe[g]  <= 1'b0;
      end else begin
        pin_out[g] <= lvl_d;
        pin_oe[g]  <= oe_d;
      end
    end
  end

endmodule

// File: rtl/pwm_force_stage.sv
module pwm_force_stage
  import pfo_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_CMP   = 8,
  parameter int CMP_IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  parameter int CMD_W     = 2 * NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    pwm_in,
  input  logic                 force_in,
  input  logic                 force_pol,
  input  logic                 sw_force,
  input  logic [NUM_CH-1:0]    src_sel,
  input  logic [NUM_CH-1:0]    ch_oe,
  input  logic [1:0]           load_mode,
  input  logic                 cmp_load_en,
  input  logic [CMP_IDX_W-1:0] cmp_sel,
  input  logic [NUM_CMP-1:0]   cmp_match,
  input  logic                 reload_pulse,
  input  logic                 sync_in,
  input  logic                 cmd_wr,
  input  logic [CMD_W-1:0]     cmd_wdata,
  output logic [NUM_CH-1:0]    pin_out,
  output logic [NUM_CH-1:0]    pin_oe
);

  logic [CMD_W-1:0]  active_cmd;
  logic [NUM_CH-1:0] force_en;

  pfo_cmd_buffer #(
    .NUM_CH    (NUM_CH),
    .NUM_CMP   (NUM_CMP),
    .CMP_IDX_W (CMP_IDX_W)
  ) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (cmd_wdata),
    .load_mode    (load_mode),
    .cmp_load_en  (cmp_load_en),
    .cmp_sel      (cmp_sel),
    .cmp_match    (cmp_match),
    .reload_pulse (reload_pulse),
    .sync_in      (sync_in),
    .active_cmd   (active_cmd)
  );

  pfo_force_enable #(
    .NUM_CH (NUM_CH)
  ) u_en (
    .force_in  (force_in),
    .force_pol (force_pol),
    .sw_force  (sw_force),
    .src_sel   (src_sel),
    .force_en  (force_en)
  );

  pfo_channel_mux #(
    .NUM_CH (NUM_CH)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .pwm_in     (pwm_in),
    .force_en   (force_en),
    .ch_oe      (ch_oe),
    .active_cmd (active_cmd),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

endmodule

// File: rtl/pfo_checker.sv
module pfo_checker #(
  parameter int NUM_CH = 8,
  parameter int CMD_W  = 2 * NUM_CH
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_oe,
  input logic [NUM_CH-1:0] pin_out,
  input logic [NUM_CH-1:0] pin_oe,
  input logic [1:0]        load_mode,
  input logic              cmp_load_en,
  input logic              cmd_wr,
  input logic [CMD_W-1:0]  cmd_wdata,
  input logic              reload_pulse,
  input logic              sync_in,
  input logic [CMD_W-1:0]  active_cmd
);

  assert_released_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_oe != {NUM_CH{1'b1}}) |=> ((pin_oe & ~$past(ch_oe)) == '0));

  assert_hiz_data_low_R2: assert property (@(posedge clk) disable iff (rst)
    ((~pin_oe & pin_out) == '0));

  assert_write_loads_now_R7: assert property (@(posedge clk) disable iff (rst)
    (load_mode == 2'd0 && !cmp_load_en && cmd_wr) |=> (active_cmd == $past(cmd_wdata)));

  assert_reload_only_R8: assert property (@(posedge clk) disable iff (rst)
    (load_mode == 2'd1 && !cmp_load_en && !reload_pulse) |=> $stable(active_cmd));

  assert_sync_only_R9: assert property (@(posedge clk) disable iff (rst)
    (load_mode == 2'd2 && !cmp_load_en && !sync_in) |=> $stable(active_cmd));

  assert_never_loads_R10: assert property (@(posedge clk) disable iff (rst)
    (load_mode == 2'd3 && !cmp_load_en) |=> $stable(active_cmd));

endmodule

bind pwm_force_stage pfo_checker #(
  .NUM_CH (NUM_CH),
  .CMD_W  (CMD_W)
) u_pfo_checker (
  .clk          (clk),
  .rst          (rst),
  .ch_oe        (ch_oe),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .load_mode    (load_mode),
  .cmp_load_en  (cmp_load_en),
  .cmd_wr       (cmd_wr),
  .cmd_wdata    (cmd_wdata),
  .reload_pulse (reload_pulse),
  .sync_in      (sync_in),
  .active_cmd   (active_cmd)
);

// File: tb/test_pwm_force_stage.sv
module test_pwm_force_stage;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int NUM_CMP    = 8;
  localparam int CMP_IDX_W  = 3;
  localparam int CMD_W      = 16;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [7:0]  src;
    logic        sw;
    logic        fin;
    logic        pol;
    logic [7:0]  oe;
    logic [7:0]  pwm;
    logic [15:0] cmd;
    logic [7:0]  exp_out;
    logic [7:0]  exp_oe;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 16'hFFFF, 8'hA5, 8'hFF}, // R5 code 3
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 16'h0000, 8'h00, 8'hFF}, // R1 low
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 16'h5555, 8'hFF, 8'hFF}, // R1 high
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 16'hAAAA, 8'h00, 8'h00}, // R2 hiz
    '{8'hFF, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hA5, 16'hAAAA, 8'hA5, 8'hFF}, // R5 inactive
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 16'hE4E4, 8'h22, 8'hBB}, // R1 mixed
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 16'hE4E4, 8'hAA, 8'hBB}, // R1 mixed
    '{8'h00, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 16'h0000, 8'h00, 8'hFF}, // R3/R4 ext high
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 16'h0000, 8'hFF, 8'hFF}, // R4 low-active idle
    '{8'h00, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 16'h0000, 8'h00, 8'hFF}, // R4 low-active on
    '{8'h0F, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 16'h0000, 8'hF0, 8'hFF}, // R3 mixed source
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'h0F, 8'hFF, 16'hFFFF, 8'h0F, 8'h0F}, // R6
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hF0, 8'h00, 16'h5555, 8'hF0, 8'hF0}  // R6
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NUM_CH-1:0]    pwm_in = '0;
  logic                 force_in = 1'b0;
  logic                 force_pol = 1'b0;
  logic                 sw_force = 1'b0;
  logic [NUM_CH-1:0]    src_sel = '0;
  logic [NUM_CH-1:0]    ch_oe = '0;
  logic [1:0]           load_mode = 2'd0;
  logic                 cmp_load_en = 1'b0;
  logic [CMP_IDX_W-1:0] cmp_sel = '0;
  logic [NUM_CMP-1:0]   cmp_match = '0;
  logic                 reload_pulse = 1'b0;
  logic                 sync_in = 1'b0;
  logic                 cmd_wr = 1'b0;
  logic [CMD_W-1:0]     cmd_wdata = '0;
  logic [NUM_CH-1:0]    pin_out;
  logic [NUM_CH-1:0]    pin_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_force_stage #(
    .NUM_CH  (NUM_CH),
    .NUM_CMP (NUM_CMP)
  ) i_pwm_force_stage (
    .clk          (clk),
    .rst          (rst),
    .pwm_in       (pwm_in),
    .force_in     (force_in),
    .force_pol    (force_pol),
    .sw_force     (sw_force),
    .src_sel      (src_sel),
    .ch_oe        (ch_oe),
    .load_mode    (load_mode),
    .cmp_load_en  (cmp_load_en),
    .cmp_sel      (cmp_sel),
    .cmp_match    (cmp_match),
    .reload_pulse (reload_pulse),
    .sync_in      (sync_in),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (cmd_wdata),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );

  task automatic check(input string req, input logic [7:0] exp_out, input logic [7:0] exp_oe);
    n_checks++;
    if (pin_out !== exp_out || pin_oe !== exp_oe) begin
      n_fail++;
      $display("FAIL %s: pin_out=%h pin_oe=%h expected pin_out=%h pin_oe=%h",
               req, pin_out, pin_oe, exp_out, exp_oe);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_write(input logic [15:0] w);
    cmd_wdata = w;
    cmd_wr    = 1'b1;
    @(negedge clk);
    cmd_wr    = 1'b0;
  endtask

  initial begin
    idle(3);
    check("R13 reset", 8'h00, 8'h00);
    rst = 1'b0;

    // R13: after reset every channel holds the no-force code
    src_sel = 8'hFF; sw_force = 1'b1; ch_oe = 8'hFF; pwm_in = 8'h3C;
    load_mode = 2'd3;
    idle(2);
    check("R13 reset command", 8'h3C, 8'hFF);

    // Table walk, each word loaded with load_mode 0
    for (int v = 0; v < NVEC; v++) begin
      src_sel = VECS[v].src; sw_force = VECS[v].sw;
      force_in = VECS[v].fin; force_pol = VECS[v].pol;
      ch_oe = VECS[v].oe; pwm_in = VECS[v].pwm;
      load_mode = 2'd0; cmp_load_en = 1'b0;
      pulse_write(VECS[v].cmd);
      @(negedge clk);
      check($sformatf("R1-table vector %0d R7", v), VECS[v].exp_out, VECS[v].exp_oe);
    end

    // R10: write all-code-0 with load_mode 3, outputs keep passing
    src_sel = 8'hFF; sw_force = 1'b1; force_in = 1'b0; force_pol = 1'b0;
    ch_oe = 8'hFF; pwm_in = 8'h3C;
    load_mode = 2'd0;
    pulse_write(16'hFFFF);
    load_mode = 2'd3;
    pulse_write(16'h0000);
    idle(2);
    check("R10 never loads", 8'h3C, 8'hFF);

    // R8: load_mode 1 waits for the reload pulse
    load_mode = 2'd1;
    idle(3);
    check("R8 no reload yet", 8'h3C, 8'hFF);
    reload_pulse = 1'b1;
    @(negedge clk);
    reload_pulse = 1'b0;
    @(negedge clk);
    check("R8 reload loads shadow", 8'h00, 8'hFF);

    // R9: load_mode 2, reload ignored, sync loads
    load_mode = 2'd2;
    pulse_write(16'h5555);
    reload_pulse = 1'b1;
    @(negedge clk);
    reload_pulse = 1'b0;
    @(negedge clk);
    check("R9 reload ignored", 8'h00, 8'hFF);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
    check("R9 sync loads", 8'hFF, 8'hFF);

    // R11: comparator 3 selected, overrides load_mode 0
    cmp_load_en = 1'b1; cmp_sel = 3'd3; load_mode = 2'd0;
    pulse_write(16'hAAAA);
    @(negedge clk);
    check("R11 write alone ignored", 8'hFF, 8'hFF);
    cmp_match = 8'b0000_0100;
    @(negedge clk);
    cmp_match = '0;
    @(negedge clk);
    check("R11 other comparator ignored", 8'hFF, 8'hFF);
    cmp_match = 8'b0000_1000;
    @(negedge clk);
    cmp_match = '0;
    @(negedge clk);
    check("R11 selected comparator loads", 8'h00, 8'h00);

    // R12: write and reload in the same cycle
    cmp_load_en = 1'b0; load_mode = 2'd1;
    cmd_wdata = 16'h0000; cmd_wr = 1'b1; reload_pulse = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; reload_pulse = 1'b0;
    @(negedge clk);
    check("R12 same-cycle write wins", 8'h00, 8'hFF);

    // R14: one edge of latency
    sw_force = 1'b0; pwm_in = 8'h00;
    idle(2);
    pwm_in = 8'h5A;
    #1;
    check("R14 before edge", 8'h00, 8'hFF);
    @(negedge clk);
    check("R14 after one edge", 8'h5A, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule